// File: doc/BRIEF.md
# LED Dimming Channel with Linear Walk

This block drives one LED from a 12-bit intensity value. A host presents a new target intensity and strobes a transfer request. From then on the channel's current intensity moves by one step at a time toward the target. The pace of those steps comes from a programmable walk divider. While the walk runs a busy flag stays high. A one-cycle completion interrupt fires when the target is reached, and an abort strobe stops the walk wherever it happens to be.

A first-order sigma-delta modulator turns the current intensity into a one-bit stream. The modulator advances on a bit tick. That tick comes from a prescaled fast tick, either divided by four (normal rate) or used directly (fast rate). A global suspend request acts according to a two-bit mode: it is ignored, it freezes the channel as it stands, or it freezes the channel and forces the output to its passive level. The passive polarity can be chosen. Clearing the enable returns the channel to a quiet reset state.

Top module: `led_dim_channel`

## Requirements
- R1: A transfer strobe (`xfer_i` high for one cycle while enabled and not frozen) loads `target_i` and raises `busy_o` at the next edge. The level then moves by one LSB every `walk_div_i`+1 cycles and stops exactly on the target. `busy_o` stays high for max(d,1)·(`walk_div_i`+1) cycles, where d is the distance (a zero-distance walk takes one tick).
- R2: `level_o` changes by at most one LSB per clock and walks correctly both upward and downward.
- R3: An abort strobe clears `busy_o` at the next edge, leaves `level_o` frozen, and raises no interrupt. An abort wins over a transfer strobe in the same cycle and over a walk tick that would complete the walk.
- R4: `done_irq_o` is high for exactly one cycle. That cycle is the first one in which `busy_o` is low after a walk reaches its target.
- R5: While `en_i` is low the channel holds `level_o`=0, `busy_o`=0, `done_irq_o`=0, and `bit_o` at the passive level, and it ignores transfer strobes.
- R6: With `susp_req_i` high and `susp_mode_i` 2'b00 or 2'b11, the suspend request has no effect, so walk timing is unchanged.
- R7: With `susp_req_i` high and `susp_mode_i`=2'b01, all state is frozen: the walk counter, the level, the busy flag and the modulator all hold. Strobes are ignored and `bit_o` keeps its value. Each frozen cycle lengthens a walk by one cycle.
- R8: With `susp_req_i` high and `susp_mode_i`=2'b10, the channel freezes as in R7 and `bit_o` is forced to the passive level.
- R9: The passive level is `passive_hi_i`, and the active bit is its inverse. With a constant level L, any 4096 consecutive bit ticks contain exactly L active bits.
- R10: For `prescale_i`=P≥1 a bit tick occurs every 4·P cycles when `fast_mode_i`=0 and every P cycles when `fast_mode_i`=1. For P=0 there are no ticks and `bit_o` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable |
| target_i | input | 12 | Target intensity, loaded on transfer |
| xfer_i | input | 1 | Transfer strobe: load target and start walk |
| abort_i | input | 1 | Abort strobe for a running walk |
| susp_req_i | input | 1 | Global suspend request |
| susp_mode_i | input | 2 | Suspend mode: 00/11 ignore, 01 freeze, 10 freeze and passive |
| prescale_i | input | 11 | Fast-tick prescaler factor, 0 stops ticks |
| fast_mode_i | input | 1 | 1: bit tick equals fast tick, 0: fast tick divided by 4 |
| walk_div_i | input | 16 | Walk tick period minus one, in clocks |
| passive_hi_i | input | 1 | Passive output level |
| bit_o | output | 1 | Modulated output bit |
| busy_o | output | 1 | Walk in progress |
| done_irq_o | output | 1 | One-cycle walk-completion pulse |
| level_o | output | 12 | Current intensity |

## Verification
Two pairs of functions can fall in the same cycle. An abort can arrive in the exact cycle in which the final walk tick would land on the target. A transfer strobe can coincide with an abort. The bench provokes the first case by counting walk-tick edges from the transfer and raising the abort one cycle before the completing edge. It then judges that no interrupt appears and that the level rests one step short of the target. For the second case it checks that no walk starts. It also overlaps a suspend window with a running walk and judges the freeze by the exact lengthening of the busy interval.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;
  typedef enum logic [1:0] {
    SUSP_IGNORE = 2'b00,
    SUSP_FREEZE = 2'b01,
    SUSP_SAFE   = 2'b10,
    SUSP_RSVD   = 2'b11
  } susp_mode_e;

  function automatic logic susp_freezes(input logic req, input susp_mode_e m);
    return req && (m == SUSP_FREEZE || m == SUSP_SAFE);
  endfunction

  function automatic logic susp_passive(input logic req, input susp_mode_e m);
    return req && (m == SUSP_SAFE);
  endfunction
endpackage

// File: rtl/led_dim_clkgen.sv
module led_dim_clkgen #(
  parameter int PSW  = 11,
  parameter int BDIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           hold_i,
  input  logic [PSW-1:0] prescale_i,
  input  logic           fast_mode_i,
  output logic           bit_tick_o
);
  localparam int QW = (BDIV > 1) ? $clog2(BDIV) : 1;
  localparam logic [QW-1:0] QLAST = QW'(BDIV - 1);

  logic [PSW-1:0] pcnt_q, pcnt_d;
  logic [QW-1:0]  qcnt_q, qcnt_d;
  logic           fast_tick;

  always_comb begin
    fast_tick = (prescale_i != '0) && (pcnt_q >= (prescale_i - PSW'(1)));
    pcnt_d = pcnt_q;
    qcnt_d = qcnt_q;
    if (!en_i) begin
      pcnt_d = '0;
      qcnt_d = '0;
    end else if (!hold_i) begin
      if (prescale_i == '0) begin
        pcnt_d = '0;
      end else if (fast_tick) begin
        pcnt_d = '0;
        qcnt_d = (qcnt_q == QLAST) ? '0 : qcnt_q + QW'(1);
      end else begin
        pcnt_d = pcnt_q + PSW'(1);
      end
    end
    bit_tick_o = en_i && !hold_i && fast_tick && (fast_mode_i || qcnt_q == QLAST);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      qcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      qcnt_q <= qcnt_d;
    end
  end

  // R10
  normal_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bit_tick_o && !fast_mode_i) |=> (!bit_tick_o || fast_mode_i));

  // R10
  stopped_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (prescale_i == '0 && $past(prescale_i) == '0) |-> !bit_tick_o);
endmodule

// File: rtl/led_dim_walker.sv
module led_dim_walker #(
  parameter int IW  = 12,
  parameter int WDW = 16
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           hold_i,
  input  logic           xfer_i,
  input  logic           abort_i,
  input  logic [IW-1:0]  target_i,
  input  logic [WDW-1:0] walk_div_i,
  output logic [IW-1:0]  level_o,
  output logic           busy_o,
  output logic           done_o
);
  logic [IW-1:0]  level_q, level_d, tgt_q, tgt_d, lvl_nx;
  logic [WDW-1:0] wcnt_q, wcnt_d;
  logic           busy_q, busy_d, done_q, done_d;

  always_comb begin
    level_d = level_q;
    tgt_d   = tgt_q;
    wcnt_d  = wcnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    lvl_nx  = (tgt_q > level_q) ? level_q + IW'(1) : level_q - IW'(1);
    if (!en_i) begin
      level_d = '0;
      tgt_d   = '0;
      wcnt_d  = '0;
      busy_d  = 1'b0;
    end else if (!hold_i) begin
      if (abort_i) begin
        busy_d = 1'b0;
        wcnt_d = '0;
      end else if (xfer_i) begin
        tgt_d  = target_i;
        busy_d = 1'b1;
        wcnt_d = '0;
      end else if (busy_q) begin
        if (wcnt_q >= walk_div_i) begin
          wcnt_d = '0;
          if (level_q == tgt_q) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            level_d = lvl_nx;
            if (lvl_nx == tgt_q) begin
              busy_d = 1'b0;
              done_d = 1'b1;
            end
          end
        end else begin
          wcnt_d = wcnt_q + WDW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      tgt_q   <= '0;
      wcnt_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      tgt_q   <= tgt_d;
      wcnt_q  <= wcnt_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign level_o = level_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  // R2
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_i |=> (level_q == $past(level_q) || level_q == $past(level_q) + IW'(1)
              || level_q == $past(level_q) - IW'(1)));

  // R3
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (abort_i && en_i && !hold_i) |=> (!busy_q && !done_q && $stable(level_q)));

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4
  done_on_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy_q));

  // R7
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hold_i && en_i) |=> ($stable(level_q) && $stable(busy_q) && !done_q));
endmodule

// File: rtl/led_dim_sdm.sv
module led_dim_sdm #(
  parameter int IW = 12
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [IW-1:0] level_i,
  output logic          bit_o
);
  logic [IW-1:0] acc_q, acc_d;
  logic          bit_q, bit_d;
  logic [IW:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, level_i};
    acc_d = acc_q;
    bit_d = bit_q;
    if (!en_i) begin
      acc_d = '0;
      bit_d = 1'b0;
    end else if (tick_i) begin
      acc_d = sum[IW-1:0];
      bit_d = sum[IW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;

  // R9
  acc_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && tick_i && level_i != '0) |=> (acc_q != $past(acc_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && !tick_i) |=> ($stable(acc_q) && $stable(bit_q)));
endmodule

// File: rtl/led_dim_channel.sv
module led_dim_channel #(
  parameter int IW   = 12,
  parameter int PSW  = 11,
  parameter int WDW  = 16,
  parameter int BDIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [IW-1:0]  target_i,
  input  logic           xfer_i,
  input  logic           abort_i,
  input  logic           susp_req_i,
  input  logic [1:0]     susp_mode_i,
  input  logic [PSW-1:0] prescale_i,
  input  logic           fast_mode_i,
  input  logic [WDW-1:0] walk_div_i,
  input  logic           passive_hi_i,
  output logic           bit_o,
  output logic           busy_o,
  output logic           done_irq_o,
  output logic [IW-1:0]  level_o
);
  import led_dim_pkg::*;

  logic [1:0] rsync_q;
  logic       rst_n;
  logic       hold, force_pas, bit_tick, raw_bit;
  susp_mode_e smode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  always_comb begin
    smode     = susp_mode_e'(susp_mode_i);
    hold      = susp_freezes(susp_req_i, smode);
    force_pas = susp_passive(susp_req_i, smode);
  end

  led_dim_clkgen #(.PSW(PSW), .BDIV(BDIV)) u_clk (
    .clk_i(clk_i), .rst_n(rst_n), .en_i(en_i), .hold_i(hold),
    .prescale_i(prescale_i), .fast_mode_i(fast_mode_i), .bit_tick_o(bit_tick)
  );

  led_dim_walker #(.IW(IW), .WDW(WDW)) u_walk (
    .clk_i(clk_i), .rst_n(rst_n), .en_i(en_i), .hold_i(hold),
    .xfer_i(xfer_i), .abort_i(abort_i), .target_i(target_i),
    .walk_div_i(walk_div_i), .level_o(level_o), .busy_o(busy_o), .done_o(done_irq_o)
  );

  led_dim_sdm #(.IW(IW)) u_sdm (
    .clk_i(clk_i), .rst_n(rst_n), .en_i(en_i), .tick_i(bit_tick),
    .level_i(level_o), .bit_o(raw_bit)
  );

  always_comb begin
    if (!en_i || force_pas) bit_o = passive_hi_i;
    else                    bit_o = raw_bit ^ passive_hi_i;
  end

  // R5
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (level_o == '0 && !busy_o && !done_irq_o));
endmodule

// File: tb/led_dim_channel_test.sv
`timescale 1ns/1ps
module led_dim_channel_test;
  logic        clk = 1'b0;
  logic        rst_n, en, xfer, abort, sreq, fmode, phi;
  logic [11:0] tgt;
  logic [1:0]  smode;
  logic [10:0] psc;
  logic [15:0] wdiv;
  logic        bit_o, busy, irq;
  logic [11:0] level;

  int nchk = 0, nbad = 0;
  int w_dur, w_irq, w_step, w_frz_bad, w_pas_bad;

  always #2 clk = ~clk;

  led_dim_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .target_i(tgt), .xfer_i(xfer),
    .abort_i(abort), .susp_req_i(sreq), .susp_mode_i(smode), .prescale_i(psc),
    .fast_mode_i(fmode), .walk_div_i(wdiv), .passive_hi_i(phi),
    .bit_o(bit_o), .busy_o(busy), .done_irq_o(irq), .level_o(level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int walk_cycles(input int from, input int to, input int div);
    int d = (to > from) ? to - from : from - to;
    if (d == 0) d = 1;
    return d * (div + 1);
  endfunction

  function automatic int ones_expected(input int p, input bit fast, input bit inv, input int l);
    int per = fast ? p : 4 * p;
    return per * (inv ? 4096 - l : l);
  endfunction

  // walk with an optional suspend window opened at negedge index sat for slen cycles
  task automatic walk(input int t, input int div, input int sat, input int slen, input logic [1:0] sm);
    int cyc = 0;
    int prev;
    logic fb;
    logic [11:0] fl;
    w_dur = 0; w_irq = 0; w_step = 0; w_frz_bad = 0; w_pas_bad = 0;
    @(negedge clk);
    tgt = 12'(t); wdiv = 16'(div); smode = sm; xfer = 1'b1;
    prev = int'(level);
    fb = bit_o; fl = level;
    forever begin
      @(negedge clk);
      xfer = 1'b0;
      cyc++;
      if (int'(level) - prev > 1 || prev - int'(level) > 1) w_step++;
      prev = int'(level);
      if (slen > 0 && cyc > sat && cyc <= sat + slen) begin
        if (sm != 2'b00 && sm != 2'b11 && (level != fl)) w_frz_bad++;
        if (sm == 2'b01 && bit_o != fb) w_frz_bad++;
        if (sm == 2'b10 && bit_o != phi) w_pas_bad++;
      end
      if (slen > 0 && cyc == sat) begin
        sreq = 1'b1; fb = bit_o; fl = level;
        if (sm == 2'b10 && bit_o != phi) w_pas_bad++;
      end
      if (slen > 0 && cyc == sat + slen) sreq = 1'b0;
      if (irq) w_irq++;
      if (!busy) break;
      w_dur++;
      if (cyc > 100000) break;
    end
    sreq = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (irq) w_irq++;
    end
  endtask

  task automatic density(input int p, input bit fast, input bit inv, input int l);
    int per = fast ? p : 4 * p;
    int ones = 0;
    @(negedge clk);
    psc = 11'(p); fmode = fast; phi = inv;
    repeat (64) @(negedge clk);
    for (int i = 0; i < per * 4096; i++) begin
      @(negedge clk);
      ones += int'(bit_o);
    end
    check(ones == ones_expected(p, fast, inv, l), fast ? "R9/R10 fast" : "R9/R10 normal",
          ones, ones_expected(p, fast, inv, l));
  endtask

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    int cur, t, d, exp, lv;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; en = 1'b1; xfer = 1'b0; abort = 1'b0; sreq = 1'b0; smode = 2'b00;
    psc = 11'd1; fmode = 1'b0; phi = 1'b0; tgt = '0; wdiv = '0;
    repeat (5) @(negedge clk);
    check(bit_o == 1'b0 && busy == 1'b0 && irq == 1'b0 && level == 12'd0, "R5 reset",
          int'({bit_o, busy, irq}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R4: directed up, down and zero-distance walks
    walk(40, 2, 0, 0, 2'b00);
    check(w_dur == walk_cycles(0, 40, 2), "R1 up duration", w_dur, walk_cycles(0, 40, 2));
    check(level == 12'd40, "R1 up level", int'(level), 40);
    check(w_irq == 1, "R4 single irq", w_irq, 1);
    walk(25, 0, 0, 0, 2'b00);
    check(w_dur == walk_cycles(40, 25, 0) && level == 12'd25, "R2 down walk", w_dur, walk_cycles(40, 25, 0));
    walk(25, 3, 0, 0, 2'b00);
    check(w_dur == walk_cycles(25, 25, 3) && w_irq == 1, "R1 zero distance", w_dur, 4);

    // R1 R2 R4: constrained random walks
    cur = 25;
    for (int k = 0; k < 10; k++) begin
      t = cur + int'($urandom % 301) - 150;
      if (t < 0) t = 0;
      if (t > 4095) t = 4095;
      d = int'($urandom % 4);
      walk(t, d, 0, 0, 2'b00);
      exp = walk_cycles(cur, t, d);
      check(w_dur == exp, "R1 random duration", w_dur, exp);
      check(int'(level) == t && w_irq == 1, "R4 random end", int'(level), t);
      check(w_step == 0, "R2 unit steps", w_step, 0);
      cur = t;
    end

    // R6: suspend ignored in modes 00 and 11
    walk(cur + 10, 1, 4, 6, 2'b00);
    check(w_dur == 20, "R6 mode 00 ignored", w_dur, 20);
    walk(cur, 1, 4, 6, 2'b11);
    check(w_dur == 20, "R6 mode 11 ignored", w_dur, 20);
    // R7: freeze lengthens walk, holds level and bit
    walk(cur + 10, 1, 5, 7, 2'b01);
    check(w_dur == 27 && w_frz_bad == 0, "R7 freeze", w_dur, 27);
    // R8: freeze with passive output
    walk(cur, 1, 5, 7, 2'b10);
    check(w_dur == 27 && w_pas_bad == 0, "R8 safe stop", w_pas_bad, 0);

    // R3: abort mid-walk
    @(negedge clk);
    tgt = 12'(cur + 50); wdiv = 16'd2; xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
    repeat (10) @(negedge clk);
    abort = 1'b1; lv = int'(level);
    @(negedge clk); abort = 1'b0;
    check(busy == 1'b0 && int'(level) == lv, "R3 abort freezes level", int'(level), lv);
    exp = 0;
    repeat (20) begin
      @(negedge clk);
      if (irq || int'(level) != lv) exp++;
    end
    check(exp == 0, "R3 no irq after abort", exp, 0);
    cur = lv;

    // R3: abort together with transfer
    @(negedge clk);
    tgt = 12'(cur + 30); xfer = 1'b1; abort = 1'b1;
    @(negedge clk); xfer = 1'b0; abort = 1'b0;
    check(busy == 1'b0, "R3 abort beats transfer", int'(busy), 0);

    // R3: abort on the completing tick
    @(negedge clk);
    tgt = 12'(cur + 3); wdiv = 16'd1; xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    check(irq == 1'b0 && busy == 1'b0 && int'(level) == cur + 2, "R3 abort beats completion",
          int'(level), cur + 2);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R3 no late irq", int'(irq), 0);

    // R9 R10: density at several clock settings
    walk(1000, 0, 0, 0, 2'b00);
    density(1, 1'b0, 1'b0, 1000);
    density(1, 1'b1, 1'b0, 1000);
    density(3, 1'b1, 1'b0, 1000);
    density(2, 1'b0, 1'b0, 1000);
    density(1, 1'b1, 1'b1, 1000);
    // R10: prescale zero stops the modulator
    @(negedge clk); psc = '0; phi = 1'b0;
    repeat (8) @(negedge clk);
    lv = int'(bit_o); exp = 0;
    repeat (300) begin
      @(negedge clk);
      if (int'(bit_o) != lv) exp++;
    end
    check(exp == 0, "R10 no clock", exp, 0);

    // R5: disable resets and ignores transfers
    @(negedge clk); en = 1'b0; phi = 1'b1;
    @(negedge clk);
    check(level == 12'd0 && busy == 1'b0 && bit_o == 1'b1, "R5 disable", int'(level), 0);
    tgt = 12'd77; xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && level == 12'd0 && irq == 1'b0, "R5 transfer ignored", int'(busy), 0);
    en = 1'b1; phi = 1'b0; psc = 11'd1;
    walk(5, 0, 0, 0, 2'b00);
    check(level == 12'd5 && w_dur == 5, "R1 walk after enable", w_dur, 5);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule